// File: doc/BRIEF.md
# Asynchronous Flash Pin Interface

This block converts the asynchronous control pins of a NOR-flash style device into clean, clock-synchronous events for the command logic and storage array behind it. The chip-enable, output-enable, write-enable, width-select and reset pins are resynchronised to the system clock. The address pins and the incoming data lines pass through the same two-stage pipeline, so all samples stay aligned. A read condition drives the array's data onto the pad outputs. Each completed write cycle becomes a single one-clock pulse that carries the latched address and data.

The pad side has separate input, output and per-bit output-enable vectors for a bidirectional 16-bit bus. In word mode all 16 lines are used. In byte mode only the low 8 lines carry data, and the top line becomes an extra least-significant address bit that selects one half of the addressed word. The array side is a combinational read port, a write pulse with its payload, and a halt flag that follows the reset pin.

Top module: `flash_pin_if`

## Requirements
- R1: While chip-enable and output-enable are low, write-enable is high and the reset pin is high, `rd_en` is high and `rd_addr` equals the pin address. In word mode, `dq_out` then carries `rd_data` with `dq_oe` = 16'hFFFF. Outputs follow a stable pin state by the third clock edge.
- R2: If chip-enable or output-enable is high, `rd_en` is low and `dq_oe` is all zero.
- R3: A write cycle requires chip-enable and write-enable both low. Its address is the pin address sampled when the later of the two falls, not the address present at the earlier fall or after the later fall.
- R4: The write data is the value on the data lines when the earlier of chip-enable or write-enable rises. Changes before the second rise are ignored.
- R5: Every completed write cycle produces exactly one `wr_valid` pulse, one clock long. This holds when both pins rise together.
- R6: If output-enable is low when the write cycle opens, no `wr_valid` pulse is produced.
- R7: In byte mode (width-select low), a read sets `dq_oe` = 16'h00FF. `dq_out[7:0]` carries `rd_data[15:8]` when `dq_in[15]` is 1 and `rd_data[7:0]` when it is 0. `dq_out[15:8]` is zero. `dq_oe` only ever takes the values 0, 16'h00FF or 16'hFFFF.
- R8: A byte-mode write reports `wr_byte` = 1 and `wr_lsb` = `dq_in[15]` sampled at the address capture point, with `wr_data` = {8'h00, data[7:0]}. A word-mode write reports `wr_byte` = 0 and `wr_lsb` = 0.
- R9: While the reset pin is low, `halt` is high, `dq_oe` is zero and no `wr_valid` is produced. A write open when the reset pin falls is abandoned and produces no pulse after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| pin_ce_n | input | 1 | Chip-enable pin, active low |
| pin_oe_n | input | 1 | Output-enable pin, active low |
| pin_we_n | input | 1 | Write-enable pin, active low |
| pin_word_mode | input | 1 | Width select: 1 word, 0 byte |
| pin_reset_n | input | 1 | Device reset pin, active low |
| pin_addr | input | ADDR_W | Word address pins |
| dq_in | input | DATA_W | Data lines as seen at the pads |
| dq_out | output | DATA_W | Data driven toward the pads |
| dq_oe | output | DATA_W | Per-line output enable |
| rd_en | output | 1 | Read condition active |
| rd_addr | output | ADDR_W | Read word address to the array |
| rd_data | input | DATA_W | Word returned by the array |
| wr_valid | output | 1 | One-clock write event |
| wr_addr | output | ADDR_W | Latched write word address |
| wr_lsb | output | 1 | Latched byte select (byte mode) |
| wr_byte | output | 1 | Write was made in byte mode |
| wr_data | output | DATA_W | Latched write data |
| halt | output | 1 | Reset pin asserted; array operation stops |

## Verification
The sharpest collision is a reset pin falling in the same clock as the edge that would close a write. Both changes pass through the same synchroniser stages, so they reach the write tracker in one cycle. The bench provokes this by lowering the reset pin and raising write-enable at the same instant while chip-enable stays low. It expects no write pulse, `halt` high, outputs disabled, and still no pulse after the reset pin and chip-enable return high. A second overlap is chip-enable and write-enable rising together, which must yield exactly one pulse.

// File: rtl/flash_pin_if.sv
module flash_pin_if #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_ce_n,
  input  logic              pin_oe_n,
  input  logic              pin_we_n,
  input  logic              pin_word_mode,
  input  logic              pin_reset_n,
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_lsb,
  output logic              wr_byte,
  output logic [DATA_W-1:0] wr_data,
  output logic              halt
);
  localparam int HALF = DATA_W / 2;
  localparam int SEL_PIN = DATA_W - 1;
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};

  // control bits: {reset, word, oe, we, ce}
  logic [4:0]        ctl_q1, ctl_q2;
  logic [ADDR_W-1:0] a_q1, a_q2;
  logic [DATA_W-1:0] d_q1, d_q2;

  logic ce_s, we_s, oe_s, word_s, rst_s;
  assign ce_s   = ctl_q2[0];
  assign we_s   = ctl_q2[1];
  assign oe_s   = ctl_q2[2];
  assign word_s = ctl_q2[3];
  assign rst_s  = ctl_q2[4];

  logic wr_low, wr_low_d, in_wr;
  logic [ADDR_W-1:0] cap_addr;
  logic cap_lsb, cap_byte;

  assign wr_low = ~ce_s & ~we_s;

  logic write_open, write_close, rd_active, sel_hi;
  assign write_open  = wr_low & ~wr_low_d & oe_s & rst_s & ~in_wr;
  assign write_close = in_wr & ~wr_low;
  assign rd_active   = ~ce_s & ~oe_s & we_s & rst_s;
  assign sel_hi      = d_q2[SEL_PIN];

  assign rd_en   = rd_active;
  assign rd_addr = a_q2;
  assign halt    = ~rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q1 <= 5'b11111;
      ctl_q2 <= 5'b11111;
      a_q1   <= '0;
      a_q2   <= '0;
      d_q1   <= '0;
      d_q2   <= '0;
    end else begin
      ctl_q1 <= {pin_reset_n, pin_word_mode, pin_oe_n, pin_we_n, pin_ce_n};
      ctl_q2 <= ctl_q1;
      a_q1   <= pin_addr;
      a_q2   <= a_q1;
      d_q1   <= dq_in;
      d_q2   <= d_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_d <= 1'b0;
      in_wr    <= 1'b0;
      cap_addr <= '0;
      cap_lsb  <= 1'b0;
      cap_byte <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_lsb   <= 1'b0;
      wr_byte  <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_low_d <= wr_low;
      wr_valid <= 1'b0;
      if (!rst_s) begin
        in_wr <= 1'b0;
      end else if (write_open) begin
        in_wr    <= 1'b1;
        cap_addr <= a_q2;
        cap_lsb  <= ~word_s & sel_hi;
        cap_byte <= ~word_s;
      end else if (write_close) begin
        in_wr    <= 1'b0;
        wr_valid <= 1'b1;
        wr_addr  <= cap_addr;
        wr_lsb   <= cap_lsb;
        wr_byte  <= cap_byte;
        wr_data  <= cap_byte ? (d_q2 & LOW_MASK) : d_q2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= '0;
      dq_out <= '0;
    end else begin
      if (!rd_active)  dq_oe <= '0;
      else if (word_s) dq_oe <= '1;
      else             dq_oe <= LOW_MASK;
      if (word_s) dq_out <= rd_data;
      else dq_out <= {{(DATA_W-HALF){1'b0}},
                      sel_hi ? rd_data[DATA_W-1:HALF] : rd_data[HALF-1:0]};
    end
  end

  assert_oe_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != '0) |-> $past(rd_en));

  assert_oe_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) || (dq_oe == LOW_MASK) || (dq_oe == '1));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_open_needs_oe_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_wr) |-> $past(oe_s));

  assert_byte_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_byte) |-> (wr_data[DATA_W-1:HALF] == '0));

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!wr_valid && dq_oe == '0));
endmodule

// File: tb/flash_pin_if_bench.sv
module flash_pin_if_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic ce_n, oe_n, we_n, word, reset_n;
  logic [18:0] addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out, dq_oe, rd_data, wr_data;
  logic rd_en, wr_valid, wr_lsb, wr_byte, halt;
  logic [18:0] rd_addr, wr_addr;

  flash_pin_if u_flash_pin_if (
    .clk(clk), .rst_n(rst_n), .pin_ce_n(ce_n), .pin_oe_n(oe_n), .pin_we_n(we_n),
    .pin_word_mode(word), .pin_reset_n(reset_n), .pin_addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_byte(wr_byte),
    .wr_data(wr_data), .halt(halt));

  function automatic logic [15:0] mem(input logic [18:0] a);
    return a[15:0] ^ 16'h3C5A;
  endfunction
  assign rd_data = mem(rd_addr);

  int checks = 0, failures = 0;
  int pulse_cnt = 0, long_cnt = 0;
  logic prev_v = 1'b0;
  logic [18:0] got_addr;
  logic [15:0] got_data;
  logic got_lsb, got_byte;

  always @(negedge clk) begin
    if (wr_valid) begin
      pulse_cnt++;
      if (prev_v) long_cnt++;
      got_addr = wr_addr; got_data = wr_data; got_lsb = wr_lsb; got_byte = wr_byte;
    end
    prev_v = wr_valid;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic wr_cycle(input bit ce_first, input bit same_rise,
                          input logic [18:0] a_early, input logic [18:0] a_cap,
                          input logic [18:0] a_late, input logic [15:0] d_early,
                          input logic [15:0] d_cap, input logic [15:0] d_late);
    oe_n = 1'b1; addr = a_early; dq_in = d_early; settle();
    if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
    settle();
    addr = a_cap; settle();
    if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
    settle();
    addr = a_late; dq_in = d_cap; settle();
    if (same_rise) begin ce_n = 1'b1; we_n = 1'b1; end
    else if (ce_first) we_n = 1'b1;
    else ce_n = 1'b1;
    settle();
    dq_in = d_late; settle();
    ce_n = 1'b1; we_n = 1'b1; settle();
  endtask

  // {ce_n, oe_n, we_n, word, a_m1, addr[18:0], expected dq_oe[15:0]}
  localparam logic [39:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 19'h12345, 16'hFFFF},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 19'h00ABC, 16'h00FF},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h00ABC, 16'h00FF},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 19'h01234, 16'h0000},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 19'h04321, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 19'h06666, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 19'h7FFFF, 16'hFFFF},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h7FFFF, 16'h00FF}
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; word = 1'b1; reset_n = 1'b1;
    addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset oe", {16'h0, dq_oe}, 32'h0);
    chk("R5 reset wr_valid", {31'h0, wr_valid}, 32'h0);
    rst_n = 1'b1;
    settle();

    for (int i = 0; i < 8; i++) begin
      logic [39:0] v;
      logic [15:0] w, exp_out;
      v = VEC[i];
      ce_n = v[39]; oe_n = v[38]; we_n = v[37]; word = v[36];
      addr = v[34:16]; dq_in = {v[35], 15'h1234};
      settle();
      w = mem(v[34:16]);
      exp_out = v[36] ? w : {8'h00, v[35] ? w[15:8] : w[7:0]};
      chk(v[36] ? "R1/R2 oe word" : "R7 oe byte", {16'h0, dq_oe}, {16'h0, v[15:0]});
      chk("R1/R2 rd_en", {31'h0, rd_en}, {31'h0, v[15:0] != 16'h0});
      if (v[15:0] != 16'h0) begin
        chk("R1 rd_addr", {13'h0, rd_addr}, {13'h0, v[34:16]});
        chk(v[36] ? "R1 word data" : "R7 byte data", {16'h0, dq_out}, {16'h0, exp_out});
      end
    end
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; word = 1'b1; settle();
    chk("R6 no write from table (WE low with OE low)", pulse_cnt, 0);

    begin
      int base;
      base = pulse_cnt;
      wr_cycle(1'b1, 1'b0, 19'h00011, 19'h2AAAA, 19'h05555, 16'h1111, 16'hBEEF, 16'h0000);
      chk("R5 one pulse WE-controlled", pulse_cnt - base, 1);
      chk("R3 later fall address", {13'h0, got_addr}, {13'h0, 19'h2AAAA});
      chk("R4 first rise data", {16'h0, got_data}, 32'h0000BEEF);
      chk("R8 word flags", {30'h0, got_byte, got_lsb}, 32'h0);

      base = pulse_cnt;
      wr_cycle(1'b0, 1'b0, 19'h00022, 19'h7FFFE, 19'h00033, 16'h2222, 16'h8001, 16'hFFFF);
      chk("R5 one pulse CE-controlled", pulse_cnt - base, 1);
      chk("R3 later fall address CE", {13'h0, got_addr}, {13'h0, 19'h7FFFE});
      chk("R4 first rise data CE", {16'h0, got_data}, 32'h00008001);

      base = pulse_cnt;
      wr_cycle(1'b1, 1'b1, 19'h00044, 19'h00000, 19'h00055, 16'h3333, 16'hFFFF, 16'h0F0F);
      chk("R5 one pulse on simultaneous rise", pulse_cnt - base, 1);
      chk("R4 data simultaneous rise", {16'h0, got_data}, 32'h0000FFFF);

      word = 1'b0;
      base = pulse_cnt;
      wr_cycle(1'b1, 1'b0, 19'h00066, 19'h01357, 19'h00077, 16'h8000, 16'h7F5A, 16'h00A5);
      chk("R8 one pulse byte write", pulse_cnt - base, 1);
      chk("R8 byte data", {16'h0, got_data}, 32'h0000005A);
      chk("R8 byte flags", {30'h0, got_byte, got_lsb}, 32'h3);
      chk("R8 byte addr", {13'h0, got_addr}, {13'h0, 19'h01357});
      word = 1'b1; settle();

      base = pulse_cnt;
      oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b1; settle();
      we_n = 1'b0; settle();
      oe_n = 1'b1; settle();
      we_n = 1'b1; settle();
      ce_n = 1'b1; settle();
      chk("R6 no pulse when OE low at open", pulse_cnt - base, 0);

      base = pulse_cnt;
      oe_n = 1'b1; addr = 19'h0ACE1; ce_n = 1'b0; settle();
      we_n = 1'b0; settle();
      reset_n = 1'b0; we_n = 1'b1; settle();
      chk("R9 halt while reset low", {31'h0, halt}, 32'h1);
      chk("R9 no pulse on collision", pulse_cnt - base, 0);
      oe_n = 1'b0; settle();
      chk("R9 outputs off under reset read", {16'h0, dq_oe}, 32'h0);
      chk("R9 rd_en off under reset", {31'h0, rd_en}, 32'h0);
      oe_n = 1'b1; we_n = 1'b0; settle();
      reset_n = 1'b1; settle();
      we_n = 1'b1; ce_n = 1'b1; settle();
      chk("R9 abandoned write after release", pulse_cnt - base, 0);
      chk("R9 halt released", {31'h0, halt}, 32'h0);
    end

    chk("R5 no multi-cycle pulses", long_cnt, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule